// File: doc/BRIEF.md
# 32-bit Arithmetic and Logic Unit with Overflow-Safe Comparison

This block is a purely combinational arithmetic and logic unit for a simple processor datapath. A 4-bit operation code selects one function of two 32-bit operands. The result and a zero flag appear in the same cycle. The functions are:

- wrapping addition and subtraction, shared by the signed and unsigned instruction forms since no overflow trap is raised;
- four bitwise operations;
- signed and unsigned less-than tests;
- an upper-half immediate placement.

The zero flag lets branch logic test equality, or its inverse, after a subtraction.

The signed less-than test does not read only the sign of the difference. It combines that sign with the signed overflow of the subtraction, so operands of opposite sign and large magnitude still compare correctly. The unsigned test takes the inverted carry out of the subtraction `a + ~b + 1`. Both tests share one adder with the subtract path.

The block has no states. The operation code plays the part of a selector: each code names one function, and unused codes select a zero result.

Top module: `alu32_core`

## Requirements
- R1: Operation code 0 (add) gives `result = (a + b) mod 2^32`. No trap or flag is raised on overflow.
- R2: Operation code 1 (subtract) gives `result = (a - b) mod 2^32`.
- R3: The bitwise operations use these codes: 2 gives `a & b`, 3 gives `a | b`, 4 gives `a ^ b`, and 5 gives `~(a | b)`.
- R4: Operation code 6 (signed less-than) gives `result = 1` when `a < b` as two's-complement numbers, and 0 otherwise. Bits 31..1 are always 0. The answer is correct even when `a - b` overflows, for example `a = 0x80000000`, `b = 0x7FFFFFFF` gives 1.
- R5: Operation code 7 (unsigned less-than) gives `result = 1` when `a < b` as unsigned numbers, and 0 otherwise. Bits 31..1 are always 0.
- R6: Operation code 8 (upper immediate) gives `result = {b[15:0], 16'h0000}`. Operand `a` has no effect.
- R7: The `zero` output is 1 exactly when `result` equals 0. With code 1 it is therefore 1 exactly when `a == b`.
- R8: Operation codes 9 to 15 give `result = 0`, so `zero = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code (encoding in R1 to R8) |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| result | output | 32 | Selected function result |
| zero | output | 1 | High when result is all zeros |

## Verification
Because the block has no state, any fault shows at `result` and `zero` in the same cycle as the operands that expose it. An overflow correction that is missing or inverted only shows when the operands have opposite signs and the difference overflows. The extreme pair 0x7FFFFFFF and 0x80000000 is therefore applied in both orders, to both compares. A wrong carry sense in the unsigned path flips every unsigned compare of unequal operands, so random operands expose it almost at once.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NOR  = 4'd5,
        OP_SLT  = 4'd6,
        OP_SLTU = 4'd7,
        OP_LUI  = 4'd8
    } alu_op_e;
endpackage

// File: rtl/alu32_addsub.sv
module alu32_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub_en,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic             ovf
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff = sub_en ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_en};
        sum   = wide[WIDTH-1:0];
        carry = wide[WIDTH];
        ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    end
endmodule

// File: rtl/alu32_logic.sv
module alu32_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        unique case (sel)
            2'd0:    y = a & b;
            2'd1:    y = a | b;
            2'd2:    y = a ^ b;
            default: y = ~(a | b);
        endcase
    end
endmodule

// File: rtl/alu32_compare.sv
module alu32_compare (
    input  logic diff_sign,
    input  logic carry,
    input  logic ovf,
    output logic lt_signed,
    output logic lt_unsigned
);
    always_comb begin
        lt_signed   = diff_sign ^ ovf;
        lt_unsigned = ~carry;
    end
endmodule

// File: rtl/alu32_core.sv
module alu32_core #(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic             zero
);
    import alu32_pkg::*;

    localparam int HALF = WIDTH / 2;

    alu_op_e          op_e;
    logic             sub_en;
    logic [WIDTH-1:0] sum;
    logic             carry;
    logic             ovf;
    logic [WIDTH-1:0] logic_y;
    logic [1:0]       logic_sel;
    logic             lt_s;
    logic             lt_u;

    always_comb begin
        op_e      = alu_op_e'(op);
        sub_en    = (op_e != OP_ADD);
        logic_sel = 2'(op - 4'd2);
    end

    alu32_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a(a), .b(b), .sub_en(sub_en),
        .sum(sum), .carry(carry), .ovf(ovf)
    );

    alu32_logic #(.WIDTH(WIDTH)) u_logic (
        .a(a), .b(b), .sel(logic_sel), .y(logic_y)
    );

    alu32_compare u_cmp (
        .diff_sign(sum[WIDTH-1]), .carry(carry), .ovf(ovf),
        .lt_signed(lt_s), .lt_unsigned(lt_u)
    );

    always_comb begin
        case (op_e)
            OP_ADD, OP_SUB:                 result = sum;
            OP_AND, OP_OR, OP_XOR, OP_NOR:  result = logic_y;
            OP_SLT:                         result = {{(WIDTH-1){1'b0}}, lt_s};
            OP_SLTU:                        result = {{(WIDTH-1){1'b0}}, lt_u};
            OP_LUI:                         result = {b[HALF-1:0], {HALF{1'b0}}};
            default:                        result = '0;
        endcase
        zero = (result == '0);
    end

    always_comb begin
        // R4
        slt_width_chk: assert (op_e != OP_SLT || result[WIDTH-1:1] == '0);
        // R4
        slt_sign_chk: assert (!(op_e == OP_SLT && a[WIDTH-1] != b[WIDTH-1]) || result[0] == a[WIDTH-1]);
        // R5
        sltu_equal_chk: assert (!(op_e == OP_SLTU && a == b) || result == '0);
        // R6
        lui_low_chk: assert (op_e != OP_LUI || result[HALF-1:0] == '0);
        // R7
        zero_equal_chk: assert (op_e != OP_SUB || zero == (a == b));
    end
endmodule

// File: tb/alu32_core_test.sv
module alu32_core_test;
    logic        clk = 1'b0;
    logic [3:0]  op;
    logic [31:0] a, b;
    logic [31:0] result;
    logic        zero;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu32_core uut (.op(op), .a(a), .b(b), .result(result), .zero(zero));

    function automatic logic [31:0] expect_res(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
        case (o)
            4'd0: return x + y;
            4'd1: return x - y;
            4'd2: return x & y;
            4'd3: return x | y;
            4'd4: return x ^ y;
            4'd5: return ~(x | y);
            4'd6: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            4'd7: return (x < y) ? 32'd1 : 32'd0;
            4'd8: return {y[15:0], 16'h0000};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4, 4'd5: return "R3";
            4'd6: return "R4";
            4'd7: return "R5";
            4'd8: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic run(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] e;
        @(posedge clk);
        op = o; a = x; b = y;
        @(negedge clk);
        e = expect_res(o, x, y);
        checks++;
        if (result !== e) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h", req_of(o), o, x, y, result, e);
        end
        checks++;
        if (zero !== (e == 32'd0)) begin
            errors++;
            $display("FAIL R7 op=%0d a=%h b=%h zero actual=%b expected=%b", o, x, y, zero, (e == 32'd0));
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        op = 4'd0; a = 32'd0; b = 32'd0;
        // initial state: add of zeros gives zero result and zero flag (R1, R7)
        @(negedge clk);
        checks++;
        if (result !== 32'd0 || zero !== 1'b1) begin
            errors++;
            $display("FAIL R7 initial actual=%h/%b expected=00000000/1", result, zero);
        end
        // R1 wrap
        run(4'd0, 32'hFFFF_FFFF, 32'd1);
        run(4'd0, 32'h7FFF_FFFF, 32'd1);
        // R2 and R7 equality
        run(4'd1, 32'h1234_5678, 32'h1234_5678);
        run(4'd1, 32'd0, 32'd1);
        // R3
        run(4'd2, 32'hF0F0_F0F0, 32'hFF00_FF00);
        run(4'd3, 32'hF0F0_F0F0, 32'h0F0F_0000);
        run(4'd4, 32'hAAAA_AAAA, 32'hAAAA_AAAA);
        run(4'd5, 32'd0, 32'd0);
        // R4 and R5 extreme pairs, both orders
        run(4'd6, 32'h7FFF_FFFF, 32'h8000_0000);
        run(4'd6, 32'h8000_0000, 32'h7FFF_FFFF);
        run(4'd7, 32'h7FFF_FFFF, 32'h8000_0000);
        run(4'd7, 32'h8000_0000, 32'h7FFF_FFFF);
        run(4'd6, 32'h8000_0000, 32'h0000_0001);
        run(4'd6, 32'h5, 32'h5);
        run(4'd7, 32'h5, 32'h5);
        // R6 a ignored
        run(4'd8, 32'hDEAD_BEEF, 32'hFFFF_1234);
        run(4'd8, 32'h0, 32'h0001_0000);
        // R8 unused codes
        for (int k = 9; k < 16; k++) run(4'(k), 32'hFFFF_FFFF, 32'h1);
        // random mix
        void'($urandom(32'd351));
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] ro;
            logic [31:0] ra, rb;
            ro = 4'($urandom_range(0, 15));
            ra = $urandom;
            rb = ((i % 8) == 0) ? ra : $urandom;
            run(ro, ra, rb);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule